// File: doc/BRIEF.md
# Rename History Log with Sequential Rollback

This block records, in program order, every register-rename action taken by the front end of an out-of-order core. Each record pairs an instruction sequence number with the architectural register it wrote, the physical register newly handed out for it and the physical register that mapping displaced. An instruction that writes no register still leaves one record, flagged as a placeholder, so that its commit and squash can still be tracked by sequence number.

Two events shrink the log from opposite ends. A commit retires the oldest record and hands the displaced physical register back to the free list. A squash starts a walk from the youngest record toward the oldest. One record is undone per cycle: the map entry is restored to the displaced register and the freshly allocated register is returned. Recovery therefore replays the log instead of reloading a saved copy of the map. While a walk runs, the block reports busy and takes no new renames and no commits.

Top module: `rename_hist_log`

## Requirements
- R1: After reset the log is empty: `busy`, `full`, `mr_valid`, `fr_sq_valid` and `fr_cm_valid` are all 0.
- R2: A rename request is accepted in a cycle where `ren_valid` and `ren_ready` are both 1, and it appends one record at the young end. `ren_ready` is 0 while the log holds DEPTH records.
- R3: `ren_ready` is 0 when `ren_nodst` is 0 and `fl_avail` is 0. A placeholder request (`ren_nodst` = 1) does not depend on `fl_avail`.
- R4: `ren_ready` is 0 while `busy` is 1 and in any cycle where `sq_valid` is 1.
- R5: A commit in an idle cycle retires the oldest record when its sequence number is less than or equal to `cmt_seq`. If that record is not a placeholder, `fr_cm_valid` is 1 in the next cycle with `fr_cm_preg` equal to the record's displaced register.
- R6: A commit whose `cmt_seq` is smaller than the oldest record's sequence number, or that arrives when the log is empty, is ignored: no free-list return, and the record stays.
- R7: Committing a placeholder record removes it and produces no free-list return.
- R8: A squash removes, youngest first, every record whose sequence number is greater than `sq_seq`, one record per cycle. For each non-placeholder record, `mr_valid` and `fr_sq_valid` pulse together, carrying that record's architectural register and displaced register on `mr_areg`/`mr_preg`, and its new register on `fr_sq_preg`. Placeholders are removed without output.
- R9: `busy` rises in the cycle after `sq_valid`. It stays high for one cycle more than the number of records the squash removes, so a squash that finds nothing to remove holds `busy` for exactly one cycle.
- R10: A commit presented while `busy` is 1 or together with `sq_valid` is ignored.
- R11: A squash presented during a walk lowers the walk's bound to the smaller of the two sequence numbers.
- R12: `full` is 1 exactly when the log holds DEPTH records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename record offered |
| ren_seq | input | SEQ_W | Sequence number of the renaming instruction |
| ren_areg | input | AREG_W | Architectural destination register |
| ren_new_preg | input | PREG_W | Physical register newly allocated |
| ren_old_preg | input | PREG_W | Physical register the mapping held before |
| ren_nodst | input | 1 | Instruction writes no register (placeholder record) |
| fl_avail | input | PREG_W+1 | Number of registers currently on the free list |
| ren_ready | output | 1 | Record can be accepted this cycle |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Sequence number being committed |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Records younger than this are undone |
| busy | output | 1 | Squash walk in progress |
| full | output | 1 | Log holds DEPTH records |
| mr_valid | output | 1 | Map restore strobe |
| mr_areg | output | AREG_W | Architectural register to restore |
| mr_preg | output | PREG_W | Physical register to put back in the map |
| fr_sq_valid | output | 1 | Free-list return from a squash |
| fr_sq_preg | output | PREG_W | Register returned by the squash walk |
| fr_cm_valid | output | 1 | Free-list return from a commit |
| fr_cm_preg | output | PREG_W | Register returned by a commit |

## Verification
A corrupted pointer or count inside the log shows up at the next commit or squash. The wrong register comes out on `fr_cm_preg` or `mr_preg`, or a return is missing or extra, one cycle after the event. A bad walk bound or walk state changes how long `busy` stays high and how many restore pulses appear, so it is visible within the walk itself. A wrong fullness count shows on `full` and `ren_ready` in the cycle after the push that exposes it. The bench keeps its own ordered model of the log and compares every restore, every return and the walk length against it.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {WK_IDLE, WK_RUN} walk_st_e;
endpackage

// File: rtl/hb_log.sv
module hb_log #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  w_seq,
  input  logic [AREG_W-1:0] w_areg,
  input  logic [PREG_W-1:0] w_newp,
  input  logic [PREG_W-1:0] w_oldp,
  input  logic              w_hole,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic [SEQ_W-1:0]  old_seq,
  output logic              old_hole,
  output logic [PREG_W-1:0] old_oldp,
  output logic [SEQ_W-1:0]  yng_seq,
  output logic [AREG_W-1:0] yng_areg,
  output logic [PREG_W-1:0] yng_newp,
  output logic [PREG_W-1:0] yng_oldp,
  output logic              yng_hole,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [SEQ_W-1:0]  m_seq  [DEPTH];
  logic [AREG_W-1:0] m_areg [DEPTH];
  logic [PREG_W-1:0] m_newp [DEPTH];
  logic [PREG_W-1:0] m_oldp [DEPTH];
  logic              m_hole [DEPTH];

  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d, yng_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    yng_idx = (wr_q == '0) ? LAST : wr_q - 1'b1;
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (pop_old) begin
      rd_d  = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_d - 1'b1;
    end
    if (pop_young) begin
      wr_d  = yng_idx;
      cnt_d = cnt_d - 1'b1;
    end else if (push) begin
      wr_d  = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      m_seq[wr_q]  <= w_seq;
      m_areg[wr_q] <= w_areg;
      m_newp[wr_q] <= w_newp;
      m_oldp[wr_q] <= w_oldp;
      m_hole[wr_q] <= w_hole;
    end
  end

  assign old_seq  = m_seq[rd_q];
  assign old_hole = m_hole[rd_q];
  assign old_oldp = m_oldp[rd_q];
  assign yng_seq  = m_seq[yng_idx];
  assign yng_areg = m_areg[yng_idx];
  assign yng_newp = m_newp[yng_idx];
  assign yng_oldp = m_oldp[yng_idx];
  assign yng_hole = m_hole[yng_idx];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));

  a_r12_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r8_walk_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop_young |-> !empty);
  a_r6_retire_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop_old |-> !empty);
  a_r10_no_retire_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_old |-> !pop_young);
  a_r4_no_push_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !pop_young);
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/hb_walk.sv
module hb_walk
  import hb_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              empty,
  input  logic [SEQ_W-1:0]  yng_seq,
  input  logic [AREG_W-1:0] yng_areg,
  input  logic [PREG_W-1:0] yng_newp,
  input  logic [PREG_W-1:0] yng_oldp,
  input  logic              yng_hole,
  output logic              busy,
  output logic              pop_young,
  output logic              rb_valid,
  output logic [AREG_W-1:0] rb_areg,
  output logic [PREG_W-1:0] rb_oldp,
  output logic [PREG_W-1:0] rb_newp
);
  walk_st_e          st_q, st_d;
  logic [SEQ_W-1:0]  tgt_q, tgt_d;
  logic              rbv_q;
  logic [AREG_W-1:0] rba_q;
  logic [PREG_W-1:0] rbo_q, rbn_q;

  always_comb begin
    pop_young = (st_q == WK_RUN) && !empty && (yng_seq > tgt_q);
    st_d  = st_q;
    tgt_d = tgt_q;
    case (st_q)
      WK_IDLE: begin
        if (sq_valid) begin
          st_d  = WK_RUN;
          tgt_d = sq_seq;
        end
      end
      default: begin
        if (sq_valid && (sq_seq < tgt_q)) tgt_d = sq_seq;
        if (!pop_young && !sq_valid) st_d = WK_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      tgt_q <= '0;
      rbv_q <= 1'b0;
      rba_q <= '0;
      rbo_q <= '0;
      rbn_q <= '0;
    end else begin
      st_q  <= st_d;
      rbv_q <= pop_young && !yng_hole;
      if (sq_valid) tgt_q <= tgt_d;
      if (pop_young) begin
        rba_q <= yng_areg;
        rbo_q <= yng_oldp;
        rbn_q <= yng_newp;
      end
    end
  end

  assign busy     = (st_q == WK_RUN);
  assign rb_valid = rbv_q;
  assign rb_areg  = rba_q;
  assign rb_oldp  = rbo_q;
  assign rb_newp  = rbn_q;

  a_r9_restore_within_walk: assert property (@(posedge clk) disable iff (!rst_n)
    rbv_q |-> (st_q == WK_RUN));
  a_r11_bound_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == WK_RUN) && $past(st_q == WK_RUN)) |-> (tgt_q <= $past(tgt_q)));
  a_r9_walk_starts_on_squash: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sq_valid));
endmodule

// File: rtl/hb_retire.sv
module hb_retire #(
  parameter int SEQ_W  = 16,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              allow,
  input  logic              empty,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic              old_hole,
  input  logic [PREG_W-1:0] old_oldp,
  output logic              pop_old,
  output logic              fc_valid,
  output logic [PREG_W-1:0] fc_preg
);
  logic              fcv_q;
  logic [PREG_W-1:0] fcp_q;

  always_comb begin
    pop_old = cmt_valid && allow && !empty && !(old_seq > cmt_seq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcv_q <= 1'b0;
      fcp_q <= '0;
    end else begin
      fcv_q <= pop_old && !old_hole;
      if (pop_old && !old_hole) fcp_q <= old_oldp;
    end
  end

  assign fc_valid = fcv_q;
  assign fc_preg  = fcp_q;

  a_r5_return_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    fcv_q |-> $past(cmt_valid));
endmodule

// File: rtl/rename_hist_log.sv
module rename_hist_log #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic [SEQ_W-1:0]  ren_seq,
  input  logic [AREG_W-1:0] ren_areg,
  input  logic [PREG_W-1:0] ren_new_preg,
  input  logic [PREG_W-1:0] ren_old_preg,
  input  logic              ren_nodst,
  input  logic [PREG_W:0]   fl_avail,
  output logic              ren_ready,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic              busy,
  output logic              full,
  output logic              mr_valid,
  output logic [AREG_W-1:0] mr_areg,
  output logic [PREG_W-1:0] mr_preg,
  output logic              fr_sq_valid,
  output logic [PREG_W-1:0] fr_sq_preg,
  output logic              fr_cm_valid,
  output logic [PREG_W-1:0] fr_cm_preg
);
  logic              push, pop_old, pop_young, empty, log_full, walk_busy;
  logic [SEQ_W-1:0]  old_seq, yng_seq;
  logic              old_hole, yng_hole;
  logic [PREG_W-1:0] old_oldp, yng_newp, yng_oldp;
  logic [AREG_W-1:0] yng_areg;
  logic              rb_valid;
  logic [AREG_W-1:0] rb_areg;
  logic [PREG_W-1:0] rb_oldp, rb_newp;
  logic              idle_cycle;

  always_comb begin
    idle_cycle = !walk_busy && !sq_valid;
    ren_ready  = idle_cycle && !log_full && (ren_nodst || (fl_avail != '0));
    push       = ren_valid && ren_ready;
  end

  hb_log #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_log (
    .clk(clk), .rst_n(rst_n),
    .push(push), .w_seq(ren_seq), .w_areg(ren_areg), .w_newp(ren_new_preg),
    .w_oldp(ren_old_preg), .w_hole(ren_nodst),
    .pop_old(pop_old), .pop_young(pop_young),
    .old_seq(old_seq), .old_hole(old_hole), .old_oldp(old_oldp),
    .yng_seq(yng_seq), .yng_areg(yng_areg), .yng_newp(yng_newp),
    .yng_oldp(yng_oldp), .yng_hole(yng_hole),
    .empty(empty), .full(log_full)
  );

  hb_walk #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .empty(empty),
    .yng_seq(yng_seq), .yng_areg(yng_areg), .yng_newp(yng_newp),
    .yng_oldp(yng_oldp), .yng_hole(yng_hole),
    .busy(walk_busy), .pop_young(pop_young),
    .rb_valid(rb_valid), .rb_areg(rb_areg), .rb_oldp(rb_oldp), .rb_newp(rb_newp)
  );

  hb_retire #(.SEQ_W(SEQ_W), .PREG_W(PREG_W)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .allow(idle_cycle), .empty(empty),
    .old_seq(old_seq), .old_hole(old_hole), .old_oldp(old_oldp),
    .pop_old(pop_old), .fc_valid(fr_cm_valid), .fc_preg(fr_cm_preg)
  );

  assign busy        = walk_busy;
  assign full        = log_full;
  assign mr_valid    = rb_valid;
  assign mr_areg     = rb_areg;
  assign mr_preg     = rb_oldp;
  assign fr_sq_valid = rb_valid;
  assign fr_sq_preg  = rb_newp;
endmodule

// File: tb/tb_rename_hist_log.sv
module tb_rename_hist_log;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ren_valid, ren_nodst, cmt_valid, sq_valid;
  logic [15:0] ren_seq, cmt_seq, sq_seq;
  logic [4:0]  ren_areg;
  logic [6:0]  ren_new_preg, ren_old_preg;
  logic [7:0]  fl_avail;
  logic        ren_ready, busy, full, mr_valid, fr_sq_valid, fr_cm_valid;
  logic [4:0]  mr_areg;
  logic [6:0]  mr_preg, fr_sq_preg, fr_cm_preg;

  int nchk = 0;
  int nfail = 0;
  int nseq = 10;

  typedef struct { int seq; int areg; int newp; int oldp; bit hole; } ent_t;
  ent_t mq[$];

  always #5 clk = ~clk;

  rename_hist_log #(.DEPTH(DEPTH), .SEQ_W(16), .AREG_W(5), .PREG_W(7)) dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_seq(ren_seq), .ren_areg(ren_areg),
    .ren_new_preg(ren_new_preg), .ren_old_preg(ren_old_preg),
    .ren_nodst(ren_nodst), .fl_avail(fl_avail), .ren_ready(ren_ready),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq),
    .busy(busy), .full(full),
    .mr_valid(mr_valid), .mr_areg(mr_areg), .mr_preg(mr_preg),
    .fr_sq_valid(fr_sq_valid), .fr_sq_preg(fr_sq_preg),
    .fr_cm_valid(fr_cm_valid), .fr_cm_preg(fr_cm_preg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int n, input bit h, input int fl);
    return (n < DEPTH) && (h || (fl != 0));
  endfunction

  function automatic bit exp_retire(input int c);
    return (mq.size() > 0) && (mq[0].seq <= c);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ren(input int s, input int a, input int np, input int op,
                        input bit h, input int fl);
    bit    e;
    string tag;
    ren_valid = 1'b1; ren_seq = 16'(s); ren_areg = 5'(a);
    ren_new_preg = 7'(np); ren_old_preg = 7'(op); ren_nodst = h; fl_avail = 8'(fl);
    #1;
    e = exp_ready(mq.size(), h, fl);
    if (mq.size() >= DEPTH) tag = "R2 ready when full";
    else if (!h && fl == 0) tag = "R3 ready without free regs";
    else tag = "R2 ready";
    check(ren_ready == e, tag, int'(ren_ready), int'(e));
    step();
    if (e) mq.push_back('{seq: s, areg: a, newp: np, oldp: op, hole: h});
    ren_valid = 1'b0; ren_nodst = 1'b0;
    check(full == (mq.size() == DEPTH), "R12 full flag", int'(full), int'(mq.size() == DEPTH));
  endtask

  task automatic do_cmt(input int c);
    bit    p, v;
    string tag;
    p = exp_retire(c);
    v = p && !mq[0].hole;
    cmt_valid = 1'b1; cmt_seq = 16'(c);
    step();
    cmt_valid = 1'b0;
    if (!p) tag = "R6 stale or empty commit";
    else if (!v) tag = "R7 placeholder commit";
    else tag = "R5 commit return";
    check(fr_cm_valid == v, tag, int'(fr_cm_valid), int'(v));
    if (v) check(fr_cm_preg == 7'(mq[0].oldp), "R5 commit register", int'(fr_cm_preg), mq[0].oldp);
    if (p) void'(mq.pop_front());
  endtask

  task automatic do_sq(input int s, input bit second, input int s2, input bit poke);
    ent_t ex[$];
    int   tgt, npop, got, cycles;
    tgt  = (second && s2 < s) ? s2 : s;
    npop = 0;
    for (int i = mq.size() - 1; i >= 0; i--) begin
      if (mq[i].seq <= tgt) break;
      npop++;
      if (!mq[i].hole) ex.push_back(mq[i]);
    end
    sq_valid = 1'b1; sq_seq = 16'(s);
    step();
    sq_valid = 1'b0;
    check(busy == 1'b1, "R9 busy after squash", int'(busy), 1);
    got = 0; cycles = 0;
    for (int k = 0; k < 4 * DEPTH + 8; k++) begin
      if (!busy) break;
      cycles++;
      if (k == 0 && second) begin sq_valid = 1'b1; sq_seq = 16'(s2); end
      if (k == 0 && poke) begin
        ren_valid = 1'b1; ren_nodst = 1'b1; fl_avail = 8'd1;
        cmt_valid = 1'b1; cmt_seq = 16'hFFFF;
        #1;
        check(ren_ready == 1'b0, "R4 ready during walk", int'(ren_ready), 0);
      end
      if (mr_valid) begin
        if (got < ex.size()) begin
          check(mr_areg == 5'(ex[got].areg), "R8 restore areg", int'(mr_areg), ex[got].areg);
          check(mr_preg == 7'(ex[got].oldp), "R8 restore preg", int'(mr_preg), ex[got].oldp);
          check(fr_sq_valid && fr_sq_preg == 7'(ex[got].newp), "R8 squash return",
                int'(fr_sq_preg), ex[got].newp);
        end
        got++;
      end else begin
        check(fr_sq_valid == 1'b0, "R8 no stray return", int'(fr_sq_valid), 0);
      end
      step();
      sq_valid = 1'b0; ren_valid = 1'b0; ren_nodst = 1'b0; cmt_valid = 1'b0;
      if (k == 0 && poke)
        check(fr_cm_valid == 1'b0, "R10 commit ignored in walk", int'(fr_cm_valid), 0);
    end
    check(got == ex.size(), "R8 restore count", got, ex.size());
    if (!second) check(cycles == npop + 1, "R9 walk length", cycles, npop + 1);
    else check(got == ex.size(), "R11 lowered bound", got, ex.size());
    check(mr_valid == 1'b0, "R8 quiet after walk", int'(mr_valid), 0);
    repeat (npop) void'(mq.pop_back());
    if (poke) begin
      // R4: the refused placeholder must not have entered; the next squash at tgt finds nothing
      if (mq.size() > 0) check(mq[mq.size()-1].seq <= tgt, "R4 no entry during walk",
                               mq[mq.size()-1].seq, tgt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    ren_valid = 0; ren_nodst = 0; cmt_valid = 0; sq_valid = 0;
    ren_seq = 0; cmt_seq = 0; sq_seq = 0; ren_areg = 0;
    ren_new_preg = 0; ren_old_preg = 0; fl_avail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && full == 0, "R1 reset busy/full", int'({busy, full}), 0);
    check(mr_valid == 0 && fr_sq_valid == 0 && fr_cm_valid == 0, "R1 reset strobes",
          int'({mr_valid, fr_sq_valid, fr_cm_valid}), 0);

    do_sq(5, 0, 0, 0);
    do_cmt(3);

    do_ren(10, 1, 40, 1, 0, 0);
    do_ren(10, 1, 40, 1, 1, 0);
    do_ren(11, 2, 41, 2, 0, 3);
    do_ren(12, 3, 42, 3, 0, 2);
    do_ren(12, 4, 43, 4, 0, 2);
    do_cmt(9);
    do_cmt(10);
    do_cmt(11);
    do_ren(13, 5, 44, 5, 0, 5);
    do_ren(14, 6, 45, 6, 1, 5);
    for (int i = 0; i < 6; i++) do_ren(15 + i, 7 + i, 50 + i, 20 + i, 0, 4);
    nseq = 21;
    do_sq(17, 1, 15, 1);
    do_sq(100, 0, 0, 0);
    do_sq(12, 0, 0, 1);

    for (int it = 0; it < 700; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 5) begin
        if ($urandom % 3 != 0) nseq++;
        do_ren(nseq, int'($urandom % 32), int'($urandom % 128), int'($urandom % 128),
               ($urandom % 5) == 0, int'($urandom % 4));
      end else if (r < 8) begin
        int c, o;
        o = (mq.size() > 0) ? mq[0].seq : nseq;
        case ($urandom % 3)
          0: c = o;
          1: c = (o > 0) ? o - 1 : 0;
          default: c = o + 1;
        endcase
        do_cmt(c);
      end else begin
        int lo, s;
        lo = (mq.size() > 0) ? mq[0].seq : nseq;
        s  = lo + int'($urandom % (nseq - lo + 2)) - 1;
        if (s < 0) s = 0;
        do_sq(s, ($urandom % 4) == 0, (s > 0) ? s - 1 : 0, ($urandom % 3) == 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule